// File: doc/BRIEF.md
# Age-Counter Page Translation Buffer

This block caches recent virtual-to-physical page translations. Every entry carries a valid flag, a tag taken from the virtual page number, and the physical page number it maps to. A virtual address is split into a page offset (ignored), a set index and a tag; all ways of the indexed set are compared in parallel, and the answer appears one clock later. With `NUM_SETS = 1` the buffer is fully associative; with `WAYS = 1` it is direct-mapped and has no age counters; anything between is set-associative. `NUM_SETS` must be a power of two. `OFFSET_W` selects the page size, for example 12 for 4 KiB pages or 14 for 16 KiB pages.

After a miss, the surrounding logic fetches the translation and presents it on the refill port. The refill picks a victim way from small per-way age counters: an empty way is used first, otherwise the least recently touched one. A separate preload port writes any entry directly, for example to set up a known state. Refill data must not duplicate a tag already valid in the same set.

Top module: `tlb_lru_buffer`

## Requirements
- R1: After reset every entry is invalid, `out_valid` is low and every age counter holds `WAYS`, so any lookup misses.
- R2: The virtual page number is `addr >> OFFSET_W`; the set is that number modulo `NUM_SETS`, and the tag is that number divided by `NUM_SETS`. The offset bits have no effect on the result.
- R3: `out_valid` is high exactly in the cycle after a cycle with `lk_valid` high.
- R4: `out_hit` is high when a valid way of the indexed set holds the lookup tag, and `out_ppn` then carries that way's page number. On a miss `out_ppn` is zero.
- R5: A refill (`fill_en`) marks the victim valid and writes its tag and page number at the next clock edge, so a lookup presented after that edge hits.
- R6: The victim is the lowest-numbered invalid way of the set, if there is one.
- R7: If all ways are valid, the victim is the way with the smallest age. Among equal smallest ages, the highest-numbered way is chosen.
- R8: A lookup hit and a refill each count as an access. All nonzero age counters of that set decrement by one, then the accessed way's counter is set to `WAYS`.
- R9: If a lookup and a refill occur in the same cycle, the lookup result reflects the contents before the refill. If both touch the same set, the refill's age update is applied first and the hit's update second.
- R10: A preload (`init_en`) writes the valid flag, tag and page number of the addressed set and way. It leaves age counters unchanged. A refill in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | VA_W | Lookup virtual address |
| out_valid | output | 1 | Lookup result valid (one cycle after request) |
| out_hit | output | 1 | Lookup hit |
| out_ppn | output | PPN_W | Physical page number on hit, zero on miss |
| fill_en | input | 1 | Refill strobe |
| fill_addr | input | VA_W | Virtual address of the refilled translation |
| fill_ppn | input | PPN_W | Physical page number to store |
| init_en | input | 1 | Preload strobe |
| init_set | input | max(1,log2 NUM_SETS) | Preload set index |
| init_way | input | max(1,log2 WAYS) | Preload way index |
| init_valid | input | 1 | Valid flag to preload |
| init_tag | input | VA_W-OFFSET_W-log2 NUM_SETS | Tag to preload |
| init_ppn | input | PPN_W | Page number to preload |

## Verification
A corrupted age counter does not show up at once. It shows up only at the next refill to that set, when the wrong way is evicted. It then becomes visible on the first later lookup of the evicted or the surviving page: one gives an unexpected miss, the other an unexpected hit. For that reason the directed sequences refill a full set and then look up every page in it. A wrong set or tag split shows on the very next lookup, as a miss or as a hit with the wrong page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Width of an index into n items, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 19,
  parameter int PPN_W  = 20,
  parameter int WAY_IW = 2
) (
  input  logic [WAYS-1:0]             row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]  row_ppn,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAY_IW-1:0]           hit_way,
  output logic [PPN_W-1:0]            hit_ppn
);
  always_comb begin
    hit_way = '0;
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = row_valid[w] && (row_tag[w] == key);
      if (hit_vec[w]) hit_way = hit_way | WAY_IW'(w);
      hit_ppn = hit_ppn | ({PPN_W{hit_vec[w]}} & row_ppn[w]);
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS   = 4,
  parameter int AGE_W  = 3,
  parameter int WAY_IW = 2
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][AGE_W-1:0] row_age,
  output logic [WAY_IW-1:0]          victim
);
  logic              found;
  logic [AGE_W-1:0]  min_age;
  logic [WAY_IW-1:0] min_way;

  always_comb begin
    found   = 1'b0;
    victim  = '0;
    min_age = row_age[0];
    min_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found) begin
        if (!row_valid[w]) begin
          victim = WAY_IW'(w);
          found  = 1'b1;
        end else if (row_age[w] <= min_age) begin
          min_age = row_age[w];
          min_way = WAY_IW'(w);
        end
      end
    end
    if (!found) victim = min_way;
  end
endmodule

// File: rtl/tlb_age_bank.sv
module tlb_age_bank #(
  parameter int WAYS   = 4,
  parameter int AGE_W  = 3,
  parameter int WAY_IW = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        a_en,
  input  logic [WAY_IW-1:0]           a_way,
  input  logic                        b_en,
  input  logic [WAY_IW-1:0]           b_way,
  output logic [WAYS-1:0][AGE_W-1:0]  ages
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS);

  logic [WAYS-1:0][AGE_W-1:0] after_a, nxt;

  function automatic logic [WAYS-1:0][AGE_W-1:0] touch(
      input logic [WAYS-1:0][AGE_W-1:0] cur, input logic [WAY_IW-1:0] w);
    logic [WAYS-1:0][AGE_W-1:0] r;
    for (int i = 0; i < WAYS; i++)
      r[i] = (cur[i] != '0) ? cur[i] - 1'b1 : cur[i];
    r[w] = AGE_MAX;
    return r;
  endfunction

  always_comb begin
    after_a = a_en ? touch(ages, a_way) : ages;
    nxt     = b_en ? touch(after_a, b_way) : after_a;
  end

  always_ff @(posedge clk) begin
    if (rst) ages <= {WAYS{AGE_MAX}};
    else     ages <= nxt;
  end
endmodule

// File: rtl/tlb_lru_buffer.sv
module tlb_lru_buffer import tlb_pkg::*; #(
  parameter int VA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int PPN_W    = 20,
  parameter int NUM_SETS = 2,
  parameter int WAYS     = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          lk_valid,
  input  logic [VA_W-1:0]                               lk_addr,
  output logic                                          out_valid,
  output logic                                          out_hit,
  output logic [PPN_W-1:0]                              out_ppn,
  input  logic                                          fill_en,
  input  logic [VA_W-1:0]                               fill_addr,
  input  logic [PPN_W-1:0]                              fill_ppn,
  input  logic                                          init_en,
  input  logic [idx_width(NUM_SETS)-1:0]                init_set,
  input  logic [idx_width(WAYS)-1:0]                    init_way,
  input  logic                                          init_valid,
  input  logic [VA_W-OFFSET_W-$clog2(NUM_SETS)-1:0]     init_tag,
  input  logic [PPN_W-1:0]                              init_ppn
);
  localparam int VPN_W  = VA_W - OFFSET_W;
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int SET_IW = idx_width(NUM_SETS);
  localparam int WAY_IW = idx_width(WAYS);
  localparam int AGE_W  = $clog2(WAYS + 1);
  localparam logic [VPN_W-1:0] SET_MASK = VPN_W'(NUM_SETS - 1);

  // Entry storage
  logic [NUM_SETS-1:0][WAYS-1:0] ent_v;
  logic [TAG_W-1:0] ent_tag [NUM_SETS][WAYS];
  logic [PPN_W-1:0] ent_ppn [NUM_SETS][WAYS];
  logic [NUM_SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  // Address split
  logic [VPN_W-1:0]  lk_vpn, f_vpn;
  logic [SET_IW-1:0] lk_set, f_set;
  logic [TAG_W-1:0]  lk_tag, f_tag;

  assign lk_vpn = lk_addr[VA_W-1:OFFSET_W];
  assign f_vpn  = fill_addr[VA_W-1:OFFSET_W];
  assign lk_set = SET_IW'(lk_vpn & SET_MASK);
  assign f_set  = SET_IW'(f_vpn & SET_MASK);
  assign lk_tag = TAG_W'(lk_vpn >> SET_W);
  assign f_tag  = TAG_W'(f_vpn >> SET_W);

  // Row selection
  logic [WAYS-1:0]             lk_row_v;
  logic [WAYS-1:0][TAG_W-1:0]  lk_row_tag;
  logic [WAYS-1:0][PPN_W-1:0]  lk_row_ppn;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_row_v[w]   = ent_v[lk_set][w];
      lk_row_tag[w] = ent_tag[lk_set][w];
      lk_row_ppn[w] = ent_ppn[lk_set][w];
    end
  end

  logic              hit;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_IW-1:0] hit_way;
  logic [PPN_W-1:0]  hit_ppn;

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .WAY_IW(WAY_IW)) u_match (
    .row_valid(lk_row_v), .row_tag(lk_row_tag), .row_ppn(lk_row_ppn), .key(lk_tag),
    .hit(hit), .hit_vec(hit_vec), .hit_way(hit_way), .hit_ppn(hit_ppn)
  );

  logic              fill_do, hit_do;
  logic [WAY_IW-1:0] victim;

  assign fill_do = fill_en && !init_en;
  assign hit_do  = lk_valid && hit;

  tlb_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_IW(WAY_IW)) u_victim (
    .row_valid(ent_v[f_set]), .row_age(age_q[f_set]), .victim(victim)
  );

  // Age counters per set; none when direct-mapped
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    if (WAYS > 1) begin : g_age
      tlb_age_bank #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_IW(WAY_IW)) u_bank (
        .clk(clk), .rst(rst),
        .a_en(fill_do && (f_set == SET_IW'(s))), .a_way(victim),
        .b_en(hit_do && (lk_set == SET_IW'(s))), .b_way(hit_way),
        .ages(age_q[s])
      );
    end else begin : g_fixed
      assign age_q[s] = {WAYS{AGE_W'(WAYS)}};
    end
  end

  // Entry writes: preload wins over refill
  always_ff @(posedge clk) begin
    if (rst)          ent_v <= '0;
    else if (init_en) ent_v[init_set][init_way] <= init_valid;
    else if (fill_en) ent_v[f_set][victim] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (init_en) begin
      ent_tag[init_set][init_way] <= init_tag;
      ent_ppn[init_set][init_way] <= init_ppn;
    end else if (fill_en) begin
      ent_tag[f_set][victim] <= f_tag;
      ent_ppn[f_set][victim] <= fill_ppn;
    end
  end

  // Registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_ppn   <= '0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= hit_do;
      out_ppn   <= hit_do ? hit_ppn : '0;
    end
  end
endmodule

// File: rtl/tlb_lru_buffer_chk.sv
module tlb_lru_buffer_chk #(
  parameter int NUM_SETS = 2,
  parameter int WAYS     = 4,
  parameter int SET_IW   = 1,
  parameter int WAY_IW   = 2,
  parameter int AGE_W    = 3
) (
  input logic                                     clk,
  input logic                                     rst,
  input logic                                     lk_valid,
  input logic                                     out_valid,
  input logic                                     out_hit,
  input logic [WAYS-1:0]                          hit_vec,
  input logic                                     hit_do,
  input logic [SET_IW-1:0]                        lk_set,
  input logic [WAY_IW-1:0]                        hit_way,
  input logic                                     fill_do,
  input logic [SET_IW-1:0]                        f_set,
  input logic [WAY_IW-1:0]                        victim,
  input logic [NUM_SETS-1:0][WAYS-1:0]            ent_v,
  input logic [NUM_SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q
);
  logic [SET_IW-1:0] last_lk_set, last_f_set;
  logic [WAY_IW-1:0] last_hit_way, last_victim;
  logic              age_ok;

  always_ff @(posedge clk) begin
    last_lk_set  <= lk_set;
    last_hit_way <= hit_way;
    last_f_set   <= f_set;
    last_victim  <= victim;
  end

  always_comb begin
    age_ok = 1'b1;
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (age_q[s][w] > AGE_W'(WAYS)) age_ok = 1'b0;
  end

  p_result_timing_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !out_valid);
  p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid);
  p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  p_fill_sets_valid_r5: assert property (@(posedge clk) disable iff (rst)
    fill_do |=> ent_v[last_f_set][last_victim]);
  p_hit_way_youngest_r8: assert property (@(posedge clk) disable iff (rst)
    hit_do |=> age_q[last_lk_set][last_hit_way] == AGE_W'(WAYS));
  p_age_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    age_ok);
endmodule

bind tlb_lru_buffer tlb_lru_buffer_chk #(
  .NUM_SETS(NUM_SETS), .WAYS(WAYS), .SET_IW(SET_IW), .WAY_IW(WAY_IW), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .out_valid(out_valid), .out_hit(out_hit),
  .hit_vec(hit_vec), .hit_do(hit_do), .lk_set(lk_set), .hit_way(hit_way),
  .fill_do(fill_do), .f_set(f_set), .victim(victim), .ent_v(ent_v), .age_q(age_q)
);

// File: tb/tlb_lru_buffer_test.sv
`timescale 1ns/1ps
module tlb_lru_buffer_test;
  localparam int NS = 2, NW = 4, OFF = 12, VAW = 32, PW = 20;
  localparam int TW = VAW - OFF - 1;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic lk_v = 0, f_v = 0, i_v = 0, i_val = 0;
  logic [VAW-1:0] lk_a = '0, f_a = '0;
  logic [PW-1:0] f_p = '0, i_p = '0;
  logic [0:0] i_s = '0;
  logic [1:0] i_w = '0;
  logic [TW-1:0] i_t = '0;
  logic out_valid, out_hit;
  logic [PW-1:0] out_ppn;

  tlb_lru_buffer uut (
    .clk(clk), .rst(rst), .lk_valid(lk_v), .lk_addr(lk_a),
    .out_valid(out_valid), .out_hit(out_hit), .out_ppn(out_ppn),
    .fill_en(f_v), .fill_addr(f_a), .fill_ppn(f_p),
    .init_en(i_v), .init_set(i_s), .init_way(i_w), .init_valid(i_val),
    .init_tag(i_t), .init_ppn(i_p)
  );

  int nchk = 0, nfail = 0;
  bit mv [NS][NW];
  int mt [NS][NW];
  int mp [NS][NW];
  int ma [NS][NW];

  function automatic logic [VAW-1:0] mk(input int vpn, input int off);
    return VAW'((vpn << OFF) | (off & 12'hFFF));
  endfunction

  function automatic int vset(input logic [VAW-1:0] a);
    return int'(a >> OFF) % NS;
  endfunction

  function automatic int vtag(input logic [VAW-1:0] a);
    return int'(a >> OFF) / NS;
  endfunction

  function automatic int pick_victim(input int s);
    int best = 0, mn = ma[s][0];
    for (int w = 0; w < NW; w++) begin
      if (!mv[s][w]) return w;
      if (ma[s][w] <= mn) begin mn = ma[s][w]; best = w; end
    end
    return best;
  endfunction

  function automatic void age_touch(input int s, input int w);
    for (int k = 0; k < NW; k++) if (ma[s][k] > 0) ma[s][k]--;
    ma[s][w] = NW;
  endfunction

  function automatic bit present(input int s, input int t, input int skip);
    for (int w = 0; w < NW; w++) if (w != skip && mv[s][w] && mt[s][w] == t) return 1;
    return 0;
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // One clock: model update from current drives, then compare results.
  task automatic cycle(input string rq);
    bit eh = 0; int ep = 0, hw = 0, ls = 0, lt = 0, fs, v;
    bit lk_now = lk_v;
    if (lk_v) begin
      ls = vset(lk_a); lt = vtag(lk_a);
      for (int w = 0; w < NW; w++)
        if (mv[ls][w] && mt[ls][w] == lt) begin eh = 1; ep = mp[ls][w]; hw = w; end
    end
    if (i_v) begin
      mv[i_s][i_w] = i_val; mt[i_s][i_w] = int'(i_t); mp[i_s][i_w] = int'(i_p);
    end else if (f_v) begin
      fs = vset(f_a); v = pick_victim(fs);
      mv[fs][v] = 1; mt[fs][v] = vtag(f_a); mp[fs][v] = int'(f_p);
      age_touch(fs, v);
    end
    if (lk_v && eh) age_touch(ls, hw);
    @(negedge clk);
    check("R3", "out_valid", int'(out_valid), int'(lk_now));
    if (lk_now) begin
      check(rq, "out_hit", int'(out_hit), int'(eh));
      check(rq, "out_ppn", int'(out_ppn), ep);
    end
    lk_v = 0; f_v = 0; i_v = 0;
  endtask

  task automatic lookup(input int vpn, input int off, input string rq);
    lk_v = 1; lk_a = mk(vpn, off); cycle(rq);
  endtask

  task automatic fill(input int vpn, input int ppn, input string rq);
    f_v = 1; f_a = mk(vpn, 0); f_p = PW'(ppn); cycle(rq);
  endtask

  task automatic preload(input int s, input int w, input bit val, input int t, input int p, input string rq);
    i_v = 1; i_s = 1'(s); i_w = 2'(w); i_val = val; i_t = TW'(t); i_p = PW'(p); cycle(rq);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; ma[s][w] = NW; end
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    for (int k = 0; k < 8; k++) lookup(k, k * 3, "R1");

    // R6 and R5: invalid ways are taken first, lowest number first
    fill(1, 101, "R5"); fill(3, 103, "R5"); fill(5, 105, "R5");
    lookup(3, 0, "R5");
    preload(1, 1, 0, 1, 0, "R10");
    fill(7, 107, "R6");
    lookup(3, 0, "R6"); lookup(7, 9, "R6"); lookup(1, 0, "R6"); lookup(5, 0, "R6");
    fill(9, 109, "R6");
    for (int k = 1; k <= 9; k += 2) lookup(k, 0, "R6");

    // R7: preloaded full set with equal ages, newest refill evicts way 3
    for (int w = 0; w < NW; w++) preload(0, w, 1, 10 + w, 200 + w, "R10");
    fill(28, 228, "R7");
    lookup(26, 0, "R7"); lookup(20, 0, "R7"); lookup(28, 0, "R7");

    // R8: hits reorder the ages before the next eviction
    lookup(22, 0, "R8"); lookup(24, 0, "R8");
    fill(30, 230, "R8");
    for (int k = 20; k <= 30; k += 2) lookup(k, 0, "R8");

    // R2: offset bits ignored, neighbouring page lands in the other set
    lookup(20, 12'hFFF, "R2"); lookup(20, 5, "R2"); lookup(21, 0, "R2");

    // R9: lookup and refill of the same set in one cycle
    lk_v = 1; lk_a = mk(22, 0); f_v = 1; f_a = mk(32, 0); f_p = 232; cycle("R9");
    for (int k = 20; k <= 32; k += 2) lookup(k, 0, "R9");

    // R10: preload blocks a refill in the same cycle
    i_v = 1; i_s = 1; i_w = 0; i_val = 1; i_t = 40; i_p = 77; f_v = 1; f_a = mk(90, 0); f_p = 5;
    cycle("R10");
    lookup(90, 0, "R10"); lookup(81, 0, "R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 8;
      lk_v = 1'($urandom % 2);
      lk_a = mk($urandom % 24, $urandom % 4096);
      if (r < 3) begin
        int vp = $urandom % 24;
        if (!present(vp % NS, vp / NS, -1)) begin
          f_v = 1; f_a = mk(vp, $urandom % 4096); f_p = PW'($urandom);
        end
      end else if (r == 3) begin
        int s = $urandom % NS, w = $urandom % NW, t = $urandom % 12;
        i_v = 1; i_s = 1'(s); i_w = 2'(w); i_t = TW'(t); i_p = PW'($urandom);
        i_val = present(s, t, w) ? 1'b0 : 1'($urandom % 4 != 0);
      end
      cycle("R4");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule